// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-master side of a processor that has an 8-bit data path and a 16-bit address. The upper address byte has its own lines. The lower address byte and the data byte share one set of lines. A client asks for one machine cycle by raising a request together with a cycle type, an address and, for writes, a data byte. The sequencer then steps through the cycle's T-states. A T-state is one period of an internal clock that runs at half the input clock rate.

In each T-state the sequencer places the address latch strobe, the shared-bus output enable, the upper-address enable, the three status lines and the active-low read and write strobes. On read-type cycles it captures the byte present on the shared lines. It then raises a completion flag for one T-state.

An external latch must use the strobe to hold the lower address byte. Instruction decode, wait states and interrupt acknowledge are handled elsewhere.

Top module: `bus_cycle_seq`

## Requirements
- R1: One T-state lasts two input clock periods. A request is taken only at a T-state boundary while `busy` is low. `busy` is high exactly for the T-states of the running cycle. A request raised while `busy` is high is ignored: it neither restarts nor alters the running cycle, and no further cycle follows it.
- R2: Memory read, memory write, I/O read, I/O write and bus idle cycles last 3 T-states. An opcode fetch lasts 4 T-states. Its fourth T-state has no strobe, no shared-bus drive and no upper-address drive.
- R3: `ale` is high only in the first input clock of T1 and is low in the second. It never rises in a bus idle cycle.
- R4: During T1, `ad_out` carries `addr[7:0]` with `ad_oe` high. `addr_hi` carries `addr[15:8]` with `addr_hi_oe` high through T1, T2 and T3. In a bus idle cycle both enables stay low. A disabled output reads 0.
- R5: The status lines {`io_m`,`s1`,`s0`} are 011 for opcode fetch, 010 for memory read, 001 for memory write, 110 for I/O read and 101 for I/O write. They are loaded when T1 begins and held until the next non-idle cycle begins. A bus idle cycle keeps the previous value. Reset gives 000.
- R6: `rd_n` is low for the whole of T2 and T3 of opcode fetch, memory read and I/O read cycles, and high at all other times. `rd_n` and `wr_n` are never low together.
- R7: In memory write and I/O write cycles, `ad_out` carries `wdata` with `ad_oe` high through T2 and T3. `wr_n` is low for T2 and the first input clock of T3, and high at all other times.
- R8: In read-type cycles `ad_oe` is low during T2 and T3. `rdata` takes the value of `ad_in` on the clock edge that ends T3, and keeps it until the next read-type cycle.
- R9: `done` is high for exactly the one T-state that follows the last T-state of a cycle, with `busy` low.
- R10: The `cyc_type` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write and 5 bus idle. Codes 6 and 7 run as bus idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Cycle request, held until `busy` rises |
| cyc_type | input | 3 | Cycle type code (R10) |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Byte to write |
| ad_in | input | 8 | Shared address/data lines as seen from outside |
| busy | output | 1 | Machine cycle in progress |
| done | output | 1 | One-T-state completion flag |
| rdata | output | 8 | Byte captured by the last read-type cycle |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for the upper address byte |
| ad_out | output | 8 | Byte driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | Status: 1 for I/O, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions take two things for granted. A requester keeps `req` and its fields steady until it sees `busy` rise. The outside world places valid read data on `ad_in` by the edge that closes T3. The stimulus changes inputs only on falling clock edges, and it drops `req` in the sample where `busy` is first seen high. It presents the read byte only during T3 and shows its complement at every other time, so a capture on the wrong edge stands out. One deliberate exception is allowed: a stray request with a different address is raised during T2 of one cycle, to show that the sequencer ignores it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Cycle type codes seen on cyc_type
    localparam logic [2:0] CT_FETCH = 3'd0;
    localparam logic [2:0] CT_MEMRD = 3'd1;
    localparam logic [2:0] CT_MEMWR = 3'd2;
    localparam logic [2:0] CT_IORD  = 3'd3;
    localparam logic [2:0] CT_IOWR  = 3'd4;
    localparam logic [2:0] CT_IDLE  = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_DONE
    } tstate_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } status_t;

    function automatic logic is_read(input logic [2:0] t);
        return (t == CT_FETCH) || (t == CT_MEMRD) || (t == CT_IORD);
    endfunction

    function automatic logic is_write(input logic [2:0] t);
        return (t == CT_MEMWR) || (t == CT_IOWR);
    endfunction

    function automatic logic is_bus(input logic [2:0] t);
        return is_read(t) || is_write(t);
    endfunction

    function automatic status_t status_of(input logic [2:0] t);
        status_t s;
        case (t)
            CT_FETCH: s = 3'b011;
            CT_MEMRD: s = 3'b010;
            CT_MEMWR: s = 3'b001;
            CT_IORD:  s = 3'b110;
            CT_IOWR:  s = 3'b101;
            default:  s = 3'b000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcs_tick.sv
// Divides the input clock into T-states: tick marks the last input clock
// of a T-state, first_half the input clocks of its first half.
module bcs_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic first_half
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick       = (cnt_q == LAST);
    assign first_half = (cnt_q < HALF);

endmodule

// File: rtl/bcs_pins.sv
// Per-T-state placement of strobes, enables and the shared-bus byte.
module bcs_pins
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e                     state,
    input  logic                        first_half,
    input  logic [2:0]                  ctype,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic                        ale,
    output logic                        ad_oe,
    output logic [DATA_W-1:0]           ad_out,
    output logic                        hi_oe,
    output logic [ADDR_W-DATA_W-1:0]    addr_hi,
    output logic                        rd_n,
    output logic                        wr_n
);
    logic bus, rd, wr, in_t1, in_mid;

    always_comb begin
        bus    = is_bus(ctype);
        rd     = is_read(ctype);
        wr     = is_write(ctype);
        in_t1  = (state == ST_T1);
        in_mid = (state == ST_T2) || (state == ST_T3);

        ale     = bus && in_t1 && first_half;
        hi_oe   = bus && (in_t1 || in_mid);
        ad_oe   = bus && (in_t1 || (wr && in_mid));
        ad_out  = !ad_oe ? '0 : (in_t1 ? addr[DATA_W-1:0] : wdata);
        addr_hi = hi_oe ? addr[ADDR_W-1:DATA_W] : '0;
        rd_n    = !(rd && in_mid);
        wr_n    = !(wr && ((state == ST_T2) || ((state == ST_T3) && first_half)));
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TDIV   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic [2:0]               cyc_type,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_hi_oe,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     rd_n,
    output logic                     wr_n
);
    typedef struct packed {
        tstate_e            state;
        logic [2:0]         ctype;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        status_t            status;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    localparam regs_t RST = '{state: ST_IDLE, ctype: CT_IDLE, addr: '0,
                              wdata: '0, status: '0, rdata: '0};

    regs_t r_d, r_q;
    logic  tick, first_half;

    bcs_tick #(.DIV(TDIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .first_half (first_half)
    );

    always_comb begin
        r_d = r_q;
        if (tick) begin
            case (r_q.state)
                ST_IDLE, ST_DONE: begin
                    if (req) begin
                        r_d.state = ST_T1;
                        r_d.ctype = cyc_type;
                        r_d.addr  = addr;
                        r_d.wdata = wdata;
                        if (is_bus(cyc_type)) r_d.status = status_of(cyc_type);
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
                ST_T1: r_d.state = ST_T2;
                ST_T2: r_d.state = ST_T3;
                ST_T3: begin
                    if (is_read(r_q.ctype)) r_d.rdata = ad_in;
                    r_d.state = (r_q.ctype == CT_FETCH) ? ST_T4 : ST_DONE;
                end
                ST_T4:   r_d.state = ST_DONE;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    bcs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state      (r_q.state),
        .first_half (first_half),
        .ctype      (r_q.ctype),
        .addr       (r_q.addr),
        .wdata      (r_q.wdata),
        .ale        (ale),
        .ad_oe      (ad_oe),
        .ad_out     (ad_out),
        .hi_oe      (addr_hi_oe),
        .addr_hi    (addr_hi),
        .rd_n       (rd_n),
        .wr_n       (wr_n)
    );

    assign busy  = (r_q.state == ST_T1) || (r_q.state == ST_T2) ||
                   (r_q.state == ST_T3) || (r_q.state == ST_T4);
    assign done  = (r_q.state == ST_DONE);
    assign rdata = r_q.rdata;
    assign io_m  = r_q.status.io_m;
    assign s1    = r_q.status.s1;
    assign s0    = r_q.status.s0;

    // A cycle starts only at a T-state boundary on a request (R1)
    assert_start_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(tick) && $past(req)));

    // The latch strobe only rises while both address bytes are driven (R3)
    assert_ale_with_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && addr_hi_oe));

    // The latch strobe drops while the cycle is still running (R3)
    assert_ale_fall_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> busy);

    // Status is frozen for the whole of a running cycle (R5)
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({io_m, s1, s0}));

    // Read and write strobes are exclusive (R6)
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // Write strobe only with write data on the shared lines (R7)
    assert_wr_data_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // Shared lines released while reading (R8)
    assert_rd_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // Completion flag only outside a running cycle (R9)
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Completion always directly follows a running cycle (R9)
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
    localparam int CLK_P = 10;
    localparam int NV    = 8;

    // {type[2:0], addr[15:0], wdata[7:0], read byte[7:0], stray request}
    localparam logic [35:0] VEC [NV] = '{
        {3'd0, 16'h12C4, 8'h00, 8'h3E, 1'b0},
        {3'd1, 16'hA55A, 8'h00, 8'h81, 1'b0},
        {3'd2, 16'h7F01, 8'hC3, 8'h00, 1'b0},
        {3'd5, 16'hFFFF, 8'h11, 8'h00, 1'b0},
        {3'd3, 16'h2323, 8'h00, 8'h5A, 1'b1},
        {3'd4, 16'h0423, 8'h96, 8'h00, 1'b0},
        {3'd7, 16'h8888, 8'h44, 8'h00, 1'b0},
        {3'd1, 16'h0000, 8'h00, 8'hFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  cyc_type = 3'd5;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        busy, done, addr_hi_oe, ad_oe, ale, io_m, s1, s0, rd_n, wr_n;
    logic [7:0]  rdata, addr_hi, ad_out;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic [2:0] exp_st = 3'b000;
    logic [7:0] exp_rd = 8'h00;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .cyc_type(cyc_type), .addr(addr),
        .wdata(wdata), .ad_in(ad_in), .busy(busy), .done(done), .rdata(rdata),
        .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pins();
        return {6'b0, ale, ad_oe, ad_out, addr_hi_oe, addr_hi,
                io_m, s1, s0, rd_n, wr_n, busy, done};
    endfunction

    function automatic logic [31:0] mk(input logic a, input logic oe, input logic [7:0] ao,
                                       input logic hoe, input logic [7:0] hi,
                                       input logic [2:0] st, input logic rn, input logic wn,
                                       input logic b, input logic d);
        return {6'b0, a, oe, ao, hoe, hi, st, rn, wn, b, d};
    endfunction

    task automatic run(input logic [35:0] v);
        logic [2:0]  t   = v[35:33];
        logic [15:0] a   = v[32:17];
        logic [7:0]  w   = v[16:9];
        logic [7:0]  rv  = v[8:1];
        logic        stray = v[0];
        logic rdk = (t == 3'd0) || (t == 3'd1) || (t == 3'd3);
        logic wrk = (t == 3'd2) || (t == 3'd4);
        logic bus = rdk || wrk;
        int   n   = (t == 3'd0) ? 4 : 3;
        int   g   = 0;
        @(negedge clk);
        req = 1'b1; cyc_type = t; addr = a; wdata = w; ad_in = ~rv;
        @(negedge clk);
        while (!busy && g < 12) begin
            @(negedge clk);
            g++;
        end
        chk("R1 busy after request", {31'b0, busy}, 32'd1);
        req = 1'b0;
        if (bus) begin
            case (t)
                3'd0: exp_st = 3'b011;
                3'd1: exp_st = 3'b010;
                3'd2: exp_st = 3'b001;
                3'd3: exp_st = 3'b110;
                default: exp_st = 3'b101;
            endcase
        end
        for (int k = 1; k <= n; k++) begin
            for (int p = 0; p < 2; p++) begin
                logic e_ale, e_oe, e_hoe, e_rn, e_wn;
                logic [7:0] e_ao, e_hi;
                if (k > 1 || p > 0) @(negedge clk);
                e_ale = bus && k == 1 && p == 0;
                e_oe  = bus && (k == 1 || (wrk && (k == 2 || k == 3)));
                e_ao  = !e_oe ? 8'h00 : (k == 1 ? a[7:0] : w);
                e_hoe = bus && k <= 3;
                e_hi  = e_hoe ? a[15:8] : 8'h00;
                e_rn  = !(rdk && (k == 2 || k == 3));
                e_wn  = !(wrk && (k == 2 || (k == 3 && p == 0)));
                // R2 R3 R4 R5 R6 R7 R8 R10: per-T-state pin placement
                chk($sformatf("R2/R3/R4/R5/R6/R7/R10 type%0d T%0d half%0d", t, k, p),
                    pins(), mk(e_ale, e_oe, e_ao, e_hoe, e_hi, exp_st, e_rn, e_wn, 1'b1, 1'b0));
                if (stray && k == 2 && p == 0) begin
                    req = 1'b1; cyc_type = 3'd2; addr = 16'hBEEF; wdata = 8'h77;
                end
                if (stray && k == 3 && p == 0) begin
                    req = 1'b0; cyc_type = t; addr = a; wdata = w;
                end
                ad_in = (k == 3) ? rv : ~rv;
            end
        end
        @(negedge clk);
        ad_in = ~rv;
        if (rdk) exp_rd = rv;
        chk("R9 done after last T-state", {30'b0, done, busy}, 32'd2);
        chk("R8 read byte captured at end of T3", {24'b0, rdata}, {24'b0, exp_rd});
        @(negedge clk);
        chk("R9 done lasts one T-state", {30'b0, done, busy}, 32'd2);
        @(negedge clk);
        chk("R9 done cleared", {30'b0, done, busy}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 no cycle without request", {31'b0, busy}, 32'd0);
        end
        chk("R5 status kept after cycle", {29'b0, io_m, s1, s0}, {29'b0, exp_st});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 R6 R9: reset state
        chk("R5/R6/R9 reset pins", pins(),
            mk(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R8 reset read byte", {24'b0, rdata}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {31'b0, busy}, 32'd0);
        for (int i = 0; i < NV; i++) begin
            run(VEC[i]);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule